// File: doc/BRIEF.md
# Rotating Calibration Scheduler with Spare Substitution

This block is the digital controller for a bank of N regular current cells plus one spare cell. At any moment exactly one of the N+1 cells is being refreshed against the reference. The other cells still have to supply N equal output currents without a break. A one-hot ring register names the cell under refresh. The ring moves one position per sample-clock enable and wraps around after the spare's position, so the schedule repeats indefinitely and needs no dedicated calibration period.

From the ring state the block drives the routing controls. Each regular terminal is fed either by its own cell or by the spare. The spare is steered onto the terminal that the cell under refresh has vacated. When the spare itself is under refresh, every regular cell feeds its own terminal and a strobe marks that cycle. All routing controls are registered together with the ring, so they all change on one clock edge. A corrupted ring, holding no ONE or more than one ONE, is reloaded to position 0 on the next edge. The analog cells, the reference and the data-path switches are outside this block.

Top module: `calib_rotator`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the ring at position 0 after that edge, whatever advEn is: cellSel = 1, termFromSpare bit 0 set, spareDest = 0.
- R2: cellSel (width N+1, bit i = cell i under refresh, bit N = spare) always has exactly one bit set after reset.
- R3: At a rising edge with advEn high and rst low, the selected position moves from index i to index i+1.
- R4: At a rising edge with advEn low and rst low, cellSel and every routing output keep their values.
- R5: An advance from position N (the spare) wraps to position 0.
- R6: While regular cell k (k < N) is selected, termFromSpare (width N, bit j = terminal j fed by the spare) has only bit k set, spareDest = k, and cellDrives (width N+1, bit i = cell i drives a terminal) has every bit set except bit k.
- R7: While the spare (position N) is selected, termFromSpare = 0, spareDest = 0, and cellDrives has all N regular bits set and bit N clear.
- R8: cellSel, termFromSpare, cellDrives, spareDest and spareCalStrobe all take their new values on the same rising edge, so they always describe the same position.
- R9: If the ring holds zero ONEs or more than one ONE, the next rising edge loads position 0, and advEn is ignored at that edge.
- R10: spareCalStrobe is high exactly in the cycles in which position N is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advEn | input | 1 | Advance the ring at this edge (one per sample period) |
| cellSel | output | NUM_OUT+1 | One-hot: the cell tied to the reference; bit NUM_OUT is the spare |
| termFromSpare | output | NUM_OUT | Bit j high: terminal j is fed by the spare instead of cell j |
| cellDrives | output | NUM_OUT+1 | Bit i high: cell i drives an output terminal |
| spareDest | output | $clog2(NUM_OUT+1) | Index of the terminal the spare feeds (0 when the spare is under refresh) |
| spareCalStrobe | output | 1 | High while the spare is under refresh |

## Verification
The hardest state to reach is a corrupted ring. No sequence on the ports can produce one, because reset and every advance keep exactly one ONE. The bench therefore overwrites the ring register for a moment between clock edges, once with all zeros and once with two ONEs, while advEn is held high. It then expects position 0 rather than an advanced position. Reaching the wrap-around from the spare position also takes a full lap of NUM_OUT+1 advances, so the bench runs two complete laps and mixes in holds.

// File: rtl/calrot_pkg.sv
package calrot_pkg;
  // strobes from the control to the ring datapath
  typedef struct packed {
    logic step;    // rotate one position
    logic reload;  // load position 0
  } ringCmd_t;
endpackage

// File: rtl/calrot_ctrl.sv
module calrot_ctrl
  import calrot_pkg::*;
(
  input  logic     rst,
  input  logic     advEn,
  input  logic     ringHealthy,
  output ringCmd_t cmd
);
  // reload wins over stepping; a broken ring is repaired before it moves
  always_comb begin
    cmd.reload = rst | ~ringHealthy;
    cmd.step   = advEn & ~cmd.reload;
  end
endmodule

// File: rtl/calrot_ring.sv
module calrot_ring
  import calrot_pkg::*;
#(
  parameter int NUM_OUT = 64
) (
  input  logic             clk,
  input  ringCmd_t         cmd,
  output logic [NUM_OUT:0] ringQ,
  output logic [NUM_OUT:0] ringNext,
  output logic             ringHealthy
);
  localparam int RING_W = NUM_OUT + 1;
  localparam logic [RING_W-1:0] HOME = RING_W'(1);

  logic [RING_W-1:0] rotated;

  assign rotated     = {ringQ[RING_W-2:0], ringQ[RING_W-1]};
  assign ringHealthy = (ringQ != '0) && ((ringQ & (ringQ - 1'b1)) == '0);

  always_comb begin
    if (cmd.reload)    ringNext = HOME;
    else if (cmd.step) ringNext = rotated;
    else               ringNext = ringQ;
  end

  always_ff @(posedge clk) begin
    ringQ <= ringNext;
  end
endmodule

// File: rtl/calrot_route.sv
module calrot_route #(
  parameter int NUM_OUT = 64,
  parameter int IDX_W   = $clog2(NUM_OUT + 1)
) (
  input  logic               clk,
  input  logic [NUM_OUT:0]   ringNext,
  output logic [NUM_OUT-1:0] termFromSpare,
  output logic [NUM_OUT:0]   cellDrives,
  output logic [IDX_W-1:0]   spareDest,
  output logic               spareCalStrobe
);
  logic [IDX_W-1:0] destNext;

  // encode which terminal the spare must cover
  always_comb begin
    destNext = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (ringNext[i]) destNext = destNext | IDX_W'(i);
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_term
      always_ff @(posedge clk) begin
        termFromSpare[g] <= ringNext[g];
        cellDrives[g]    <= ~ringNext[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    cellDrives[NUM_OUT] <= ~ringNext[NUM_OUT];
    spareCalStrobe      <= ringNext[NUM_OUT];
    spareDest           <= destNext;
  end
endmodule

// File: rtl/calib_rotator.sv
module calib_rotator
  import calrot_pkg::*;
#(
  parameter int NUM_OUT = 64,
  parameter int IDX_W   = $clog2(NUM_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advEn,
  output logic [NUM_OUT:0]   cellSel,
  output logic [NUM_OUT-1:0] termFromSpare,
  output logic [NUM_OUT:0]   cellDrives,
  output logic [IDX_W-1:0]   spareDest,
  output logic               spareCalStrobe
);
  ringCmd_t         cmd;
  logic             ringHealthy;
  logic [NUM_OUT:0] ringNext;

  calrot_ctrl u_ctrl (
    .rst        (rst),
    .advEn      (advEn),
    .ringHealthy(ringHealthy),
    .cmd        (cmd)
  );

  calrot_ring #(.NUM_OUT(NUM_OUT)) u_ring (
    .clk        (clk),
    .cmd        (cmd),
    .ringQ      (cellSel),
    .ringNext   (ringNext),
    .ringHealthy(ringHealthy)
  );

  calrot_route #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_route (
    .clk           (clk),
    .ringNext      (ringNext),
    .termFromSpare (termFromSpare),
    .cellDrives    (cellDrives),
    .spareDest     (spareDest),
    .spareCalStrobe(spareCalStrobe)
  );
endmodule

// File: rtl/calib_rotator_chk.sv
module calib_rotator_chk #(
  parameter int NUM_OUT = 64,
  parameter int IDX_W   = $clog2(NUM_OUT + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               advEn,
  input logic [NUM_OUT:0]   cellSel,
  input logic [NUM_OUT-1:0] termFromSpare,
  input logic [NUM_OUT:0]   cellDrives,
  input logic [IDX_W-1:0]   spareDest,
  input logic               spareCalStrobe
);
  logic armed = 1'b0;
  logic good;

  always_ff @(posedge clk) armed <= ~rst;
  assign good = ($countones(cellSel) == 1);

  // R3 / R5: one step per enabled edge, wrapping from the spare to 0
  a_r3_step: assert property (@(posedge clk) disable iff (rst || !armed)
    (good && $past(good) && $past(advEn)) |->
      cellSel == {$past(cellSel[NUM_OUT-1:0]), $past(cellSel[NUM_OUT])});

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst || !armed)
    (good && $past(good) && $past(advEn) && $past(cellSel[NUM_OUT])) |-> cellSel[0]);

  // R4: no enable, no movement
  a_r4_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    (good && $past(good) && !$past(advEn)) |-> $stable(cellSel) && $stable(termFromSpare));

  // R6 / R8: routing registers agree with the ring register every cycle
  a_r6_route: assert property (@(posedge clk) disable iff (rst || !armed)
    good |-> (termFromSpare == cellSel[NUM_OUT-1:0]) && $onehot0(termFromSpare));

  a_r8_drive: assert property (@(posedge clk) disable iff (rst || !armed)
    good |-> (cellDrives == ~cellSel) && (cellDrives[NUM_OUT] == (termFromSpare != '0)));

  // R7 / R10: strobe marks the spare's own refresh
  a_r10_strobe: assert property (@(posedge clk) disable iff (rst || !armed)
    good |-> (spareCalStrobe == cellSel[NUM_OUT]));

  a_r7_spare_idle: assert property (@(posedge clk) disable iff (rst || !armed)
    spareCalStrobe |-> (termFromSpare == '0) && (spareDest == '0));
endmodule

bind calib_rotator calib_rotator_chk #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .advEn         (advEn),
  .cellSel       (cellSel),
  .termFromSpare (termFromSpare),
  .cellDrives    (cellDrives),
  .spareDest     (spareDest),
  .spareCalStrobe(spareCalStrobe)
);

// File: tb/calib_rotator_tb.sv
`timescale 1ns/1ps
module calib_rotator_tb;
  localparam int N     = 64;
  localparam int IDX_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advEn = 1'b0;
  logic [N:0]   cellSel;
  logic [N-1:0] termFromSpare;
  logic [N:0]   cellDrives;
  logic [IDX_W-1:0] spareDest;
  logic spareCalStrobe;

  int nChecks = 0;
  int nFails  = 0;
  int modelIdx = 0;
  int   expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  calib_rotator #(.NUM_OUT(N)) u_dut (
    .clk(clk), .rst(rst), .advEn(advEn),
    .cellSel(cellSel), .termFromSpare(termFromSpare),
    .cellDrives(cellDrives), .spareDest(spareDest),
    .spareCalStrobe(spareCalStrobe)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [N:0] act, input logic [N:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one clock cycle, expected position pushed for the monitor
  task automatic cycle(input bit r, input bit adv);
    string tag;
    @(negedge clk);
    rst = r; advEn = adv;
    if (r) begin modelIdx = 0; tag = "R1"; end
    else if (adv) begin
      tag = (modelIdx == N) ? "R5" : "R3";
      modelIdx = (modelIdx == N) ? 0 : modelIdx + 1;
    end else tag = "R4";
    expQ.push_back(modelIdx);
    tagQ.push_back(tag);
  endtask

  // corrupt the ring between edges; the next edge must reload position 0
  task automatic corrupt(input logic [N:0] pattern);
    @(negedge clk);
    force u_dut.u_ring.ringQ = pattern;
    #0.5;
    release u_dut.u_ring.ringQ;
    rst = 1'b0; advEn = 1'b1;
    modelIdx = 0;
    expQ.push_back(0);
    tagQ.push_back("R9");
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() > 0) begin
        int idx;
        string tag;
        logic [N:0] eSel;
        logic [N-1:0] eTerm;
        logic [IDX_W-1:0] eDest;
        idx = expQ.pop_front();
        tag = tagQ.pop_front();
        eSel  = (N+1)'(1) << idx;
        eTerm = eSel[N-1:0];
        eDest = (idx < N) ? IDX_W'(idx) : '0;
        chk(cellSel == eSel, tag, cellSel, eSel);
        chk($countones(cellSel) == 1, "R2", cellSel, eSel);
        chk(spareCalStrobe == (idx == N), "R10",
            (N+1)'(spareCalStrobe), (N+1)'(idx == N));
        if (idx < N) begin
          chk(termFromSpare == eTerm, "R6", (N+1)'(termFromSpare), (N+1)'(eTerm));
          chk(spareDest == eDest, "R6", (N+1)'(spareDest), (N+1)'(eDest));
          chk(cellDrives == ~eSel, "R6", cellDrives, ~eSel);
        end else begin
          chk(termFromSpare == '0, "R7", (N+1)'(termFromSpare), '0);
          chk(spareDest == '0, "R7", (N+1)'(spareDest), '0);
          chk(cellDrives == ~eSel, "R7", cellDrives, ~eSel);
        end
        chk((termFromSpare == cellSel[N-1:0]) && (cellDrives == ~cellSel), "R8",
            (N+1)'(termFromSpare), cellSel);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    // R1: reset with advEn high
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    // R3/R5: two full laps
    for (int i = 0; i < 2 * (N + 1) + 3; i++) cycle(1'b0, 1'b1);
    // R4: holds mixed with advances
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(1'b0, lfsr[0]);
    end
    // park on the spare and hold there (R7, R10)
    while (modelIdx != N) cycle(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    // R1: reset mid-lap
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    // R9: zero ONEs and two ONEs
    for (int i = 0; i < 7; i++) cycle(1'b0, 1'b1);
    corrupt('0);
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    corrupt(((N+1)'(1) << 3) | ((N+1)'(1) << N));
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    @(negedge clk); advEn = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule